// File: doc/BRIEF.md
# Conditional Branch Step Sequencer

This block resolves a conditional relative branch for a CPU with 16-bit opcodes. On a start request it reads the opcode word, the program counter, the prefetched extension word and the four condition flags: negative, zero, overflow and carry. It tests the condition named in the opcode against the flags and computes the program counter that execution continues from. It then plays out the bus-step schedule for the branch as a stream of tokens. Each token is a single idle step, a double idle step, or a program-word fetch.

The program-counter input is the address of the displacement word. A downstream bus engine consumes the tokens over a valid/ready handshake. A one-cycle done pulse marks the end of each schedule.

The block can take a new request in the same cycle as its done pulse, so branches can run back to back.

Top module: `bcs_branch_seq`

## Requirements
- R1: The condition code is opcode bits [11:8]. With N, Z, V, C as the flag inputs, the branch is taken for each code as follows:
  - 0: always
  - 1: never
  - 2: !C&!Z
  - 3: C|Z
  - 4: !C
  - 5: C
  - 6: !Z
  - 7: Z
  - 8: !V
  - 9: V
  - 10: !N
  - 11: N
  - 12: N==V
  - 13: N!=V
  - 14: !Z&(N==V)
  - 15: Z|(N!=V)
- R2: Opcode bits [7:0] are a signed byte displacement. When that byte is 0x00 or 0xFF, the word form is used instead: the displacement is the signed 16-bit extension word.
- R3: When the branch is taken, `new_pc` is `pc_in` plus the sign-extended displacement, modulo 2^AW.
- R4: When the branch is not taken, `new_pc` is `pc_in` for the byte form and `pc_in`+2 for the word form.
- R5: Token codes on `tok_kind` are 0 for a single idle step, 1 for a double idle step and 2 for a program fetch. A taken branch emits the tokens 0, 2, 2.
- R6: A byte-form branch that is not taken emits the tokens 1, 2.
- R7: A word-form branch that is not taken emits the tokens 1, 2, 2.
- R8: A token is accepted only in a cycle where `tok_valid` and `tok_ready` are both high. While `tok_ready` is low, `tok_valid` and `tok_kind` hold.
- R9: `done` is high for exactly one cycle: the cycle after the last token is accepted. `tok_valid` is low in that cycle.
- R10: A `start` is accepted whenever `tok_valid` is low, which includes the done cycle. A `start` raised while tokens are pending has no effect on `new_pc`, `taken` or the token stream.
- R11: During reset, `tok_valid`, `done`, `taken` and `new_pc` are all zero.
- R12: `new_pc` and `taken` reflect an accepted request from the following cycle onward. They hold until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to resolve a branch |
| opcode | input | 16 | Branch opcode word |
| pc_in | input | AW | Address of the displacement word |
| ext_word | input | EXT_W | Prefetched extension word |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| tok_valid | output | 1 | Step token valid |
| tok_ready | input | 1 | Consumer accepts the token |
| tok_kind | output | 2 | Step token code |
| done | output | 1 | One-cycle end-of-schedule pulse |
| new_pc | output | AW | Resolved program counter |
| taken | output | 1 | Branch decision |

## Verification
The done pulse of one schedule and the acceptance of the next request can fall in the same cycle. The bench provokes this by raising `start` with a second opcode in the very cycle in which it observes `done`. The overlap is judged correct when the second request's program counter, decision and full token list follow with no token lost or duplicated. The bench also offers a request while tokens are stalled, and checks that the first request's results are left untouched. Around these cases, every condition code is swept against all sixteen flag combinations and five displacement forms, with a stalling ready pattern.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
   typedef enum logic [1:0] {
      TK_IDLE1 = 2'd0,
      TK_IDLE2 = 2'd1,
      TK_FETCH = 2'd2
   } step_tok_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_EMIT,
      SQ_DONE
   } seq_state_e;

   localparam int unsigned MAX_STEPS = 3;
   localparam int unsigned OPC_W     = 16;
endpackage

// File: rtl/bcs_cond_eval.sv
module bcs_cond_eval (
   input  logic [3:0] code,
   input  logic       n,
   input  logic       z,
   input  logic       v,
   input  logic       c,
   output logic       pass
);
   logic base;
   logic nv_eq;

   assign nv_eq = ~(n ^ v);

   // Odd codes are the complement of the even code below them.
   always_comb begin
      unique case (code[3:1])
         3'd0:    base = 1'b1;
         3'd1:    base = ~c & ~z;
         3'd2:    base = ~c;
         3'd3:    base = ~z;
         3'd4:    base = ~v;
         3'd5:    base = ~n;
         3'd6:    base = nv_eq;
         default: base = ~z & nv_eq;
      endcase
      pass = base ^ code[0];
   end
endmodule

// File: rtl/bcs_target.sv
module bcs_target #(
   parameter int AW    = 32,
   parameter int EXT_W = 16
) (
   input  logic [AW-1:0]    pc,
   input  logic [7:0]       disp8,
   input  logic [EXT_W-1:0] ext,
   input  logic             word_form,
   input  logic             take,
   output logic [AW-1:0]    next_pc
);
   localparam int SKIP = EXT_W / 8;

   logic [AW-1:0] off_byte;
   logic [AW-1:0] off_word;

   assign off_byte = {{(AW-8){disp8[7]}}, disp8};

   generate
      if (AW > EXT_W) begin : g_wide
         assign off_word = {{(AW-EXT_W){ext[EXT_W-1]}}, ext};
      end else begin : g_exact
         assign off_word = ext;
      end
   endgenerate

   always_comb begin
      if (take)
         next_pc = pc + (word_form ? off_word : off_byte);
      else if (word_form)
         next_pc = pc + AW'(SKIP);
      else
         next_pc = pc;
   end
endmodule

// File: rtl/bcs_step_prog.sv
module bcs_step_prog
   import bcs_pkg::*;
#(
   parameter int IW = 2
) (
   input  logic [IW-1:0] idx,
   input  logic          take,
   input  logic          word_form,
   output step_tok_e     kind,
   output logic          last
);
   logic [IW-1:0] last_idx;

   always_comb begin
      if (idx == '0)
         kind = take ? TK_IDLE1 : TK_IDLE2;
      else
         kind = TK_FETCH;
      last_idx = (!take && !word_form) ? IW'(1) : IW'(MAX_STEPS - 1);
      last     = (idx == last_idx);
   end
endmodule

// File: rtl/bcs_branch_seq.sv
module bcs_branch_seq
   import bcs_pkg::*;
#(
   parameter int AW    = 32,
   parameter int EXT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [15:0]      opcode,
   input  logic [AW-1:0]    pc_in,
   input  logic [EXT_W-1:0] ext_word,
   input  logic             flag_n,
   input  logic             flag_z,
   input  logic             flag_v,
   input  logic             flag_c,
   output logic             tok_valid,
   input  logic             tok_ready,
   output logic [1:0]       tok_kind,
   output logic             done,
   output logic [AW-1:0]    new_pc,
   output logic             taken
);
   localparam int IW = $clog2(MAX_STEPS);

   generate
      if (AW < 16 || AW > 64) begin : g_bad_aw
         $error("bcs_branch_seq: AW must lie in 16..64");
      end
      if (EXT_W < 16 || EXT_W > AW || (EXT_W % 8) != 0) begin : g_bad_ext
         $error("bcs_branch_seq: EXT_W must be a byte multiple in 16..AW");
      end
   endgenerate

   seq_state_e    state_q;
   logic [IW-1:0] idx_q;
   logic          taken_q;
   logic          wf_q;
   logic [AW-1:0] pc_q;

   logic          word_form;
   logic          cond_pass;
   logic [AW-1:0] next_pc;
   logic          accept;
   step_tok_e     kind;
   logic          last;

   assign word_form = (opcode[7:0] == 8'h00) || (opcode[7:0] == 8'hFF);
   assign accept    = start && (state_q != SQ_EMIT);

   bcs_cond_eval u_cond (
      .code (opcode[11:8]),
      .n    (flag_n),
      .z    (flag_z),
      .v    (flag_v),
      .c    (flag_c),
      .pass (cond_pass)
   );

   bcs_target #(.AW(AW), .EXT_W(EXT_W)) u_target (
      .pc        (pc_in),
      .disp8     (opcode[7:0]),
      .ext       (ext_word),
      .word_form (word_form),
      .take      (cond_pass),
      .next_pc   (next_pc)
   );

   bcs_step_prog #(.IW(IW)) u_prog (
      .idx       (idx_q),
      .take      (taken_q),
      .word_form (wf_q),
      .kind      (kind),
      .last      (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         idx_q   <= '0;
         taken_q <= 1'b0;
         wf_q    <= 1'b0;
         pc_q    <= '0;
      end else begin
         if (accept) begin
            state_q <= SQ_EMIT;
            idx_q   <= '0;
            taken_q <= cond_pass;
            wf_q    <= word_form;
            pc_q    <= next_pc;
         end else begin
            unique case (state_q)
               SQ_EMIT: begin
                  if (tok_ready) begin
                     if (last) state_q <= SQ_DONE;
                     else      idx_q   <= idx_q + IW'(1);
                  end
               end
               SQ_DONE: state_q <= SQ_IDLE;
               default: state_q <= SQ_IDLE;
            endcase
         end
      end
   end

   assign tok_valid = (state_q == SQ_EMIT);
   assign done      = (state_q == SQ_DONE);
   assign tok_kind  = kind;
   assign new_pc    = pc_q;
   assign taken     = taken_q;

   AST_TOK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid && !tok_ready |=> tok_valid && $stable(tok_kind)); // R8
   AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !tok_valid); // R9
   AST_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tok_valid) |-> done); // R9
   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid && start |=> $stable(new_pc) && $stable(taken)); // R10
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(new_pc) && $stable(taken)); // R12
   AST_TOK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid |-> tok_kind != 2'd3); // R5
   AST_FIRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tok_valid) |-> tok_kind != 2'd2); // R6
endmodule

// File: tb/bcs_branch_seq_bench.sv
module bcs_branch_seq_bench;
   localparam int AW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [15:0]   opcode = '0;
   logic [AW-1:0] pc_in = '0;
   logic [15:0]   ext_word = '0;
   logic          flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
   logic          tok_valid;
   logic          tok_ready = 1'b1;
   logic [1:0]    tok_kind;
   logic          done;
   logic [AW-1:0] new_pc;
   logic          taken;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int stall_ph = 0;

   always #2 clk = ~clk;

   bcs_branch_seq #(.AW(AW), .EXT_W(16)) u_bcs_branch_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .pc_in(pc_in), .ext_word(ext_word),
      .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
      .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_kind(tok_kind),
      .done(done), .new_pc(new_pc), .taken(taken)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // R1 truth table
   function automatic bit exp_cond(input logic [3:0] cc, input bit n, z, v, c);
      case (cc)
         4'h0: return 1'b1;
         4'h1: return 1'b0;
         4'h2: return !c && !z;
         4'h3: return c || z;
         4'h4: return !c;
         4'h5: return c;
         4'h6: return !z;
         4'h7: return z;
         4'h8: return !v;
         4'h9: return v;
         4'hA: return !n;
         4'hB: return n;
         4'hC: return n == v;
         4'hD: return n != v;
         4'hE: return !z && (n == v);
         default: return z || (n != v);
      endcase
   endfunction

   function automatic logic [AW-1:0] exp_pc(input logic [15:0] op, input logic [15:0] ext,
                                            input logic [AW-1:0] pc, input bit tk);
      bit wf = (op[7:0] == 8'h00) || (op[7:0] == 8'hFF);
      logic [AW-1:0] d8 = {{(AW-8){op[7]}}, op[7:0]};
      logic [AW-1:0] d16 = {{(AW-16){ext[15]}}, ext};
      if (tk) return wf ? pc + d16 : pc + d8;
      return wf ? pc + 24'd2 : pc;
   endfunction

   task automatic drive_start(input logic [15:0] op, input logic [15:0] ext,
                              input logic [AW-1:0] pc, input logic [3:0] fl);
      opcode = op; ext_word = ext; pc_in = pc;
      {flag_n, flag_z, flag_v, flag_c} = fl;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // Collects tokens until done; returns with done observed at this negedge.
   task automatic drain(output logic [5:0] seq, output int ntok, output bit seen);
      seq = '0; ntok = 0; seen = 0;
      for (int i = 0; i < 40; i++) begin
         if (done) begin
            seen = 1;
            check(!tok_valid, "R9", tok_valid, 0);
            break;
         end
         if (tok_valid) begin
            stall_ph = stall_ph + 1;
            tok_ready = (stall_ph % 3) != 0;
            if (tok_ready) begin
               seq = {seq[3:0], tok_kind};
               ntok = ntok + 1;
            end
         end
         @(negedge clk);
      end
      tok_ready = 1'b1;
   endtask

   task automatic check_seq(input bit tk, input logic [15:0] op, input logic [5:0] seq, input int ntok);
      bit wf = (op[7:0] == 8'h00) || (op[7:0] == 8'hFF);
      if (tk)
         check(seq == 6'b00_10_10 && ntok == 3, "R5", {ntok, seq}, {3, 6'b001010});
      else if (!wf)
         check(seq == 6'b00_01_10 && ntok == 2, "R6", {ntok, seq}, {2, 6'b000110});
      else
         check(seq == 6'b01_10_10 && ntok == 3, "R7", {ntok, seq}, {3, 6'b011010});
   endtask

   initial begin
      logic [7:0]  lows [5] = '{8'h00, 8'hFF, 8'h7F, 8'h80, 8'h05};
      logic [5:0]  seq;
      int          ntok;
      bit          seen;
      int          run = 0;

      #1;
      check(!tok_valid && !done && !taken && new_pc == '0, "R11",
            {tok_valid, done, taken}, 0);
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!tok_valid && !done && new_pc == '0, "R11", new_pc, 0);

      // Sweep: every code x every flag set x displacement forms (R1..R9, R12)
      for (int cc = 0; cc < 16; cc++) begin
         for (int fl = 0; fl < 16; fl++) begin
            for (int d = 0; d < 5; d++) begin
               logic [15:0]   op  = {4'h6, 4'(cc), lows[d]};
               logic [15:0]   ext = run[0] ? 16'h8002 : 16'h7FFE;
               logic [AW-1:0] pc  = 24'hFFFF00 + AW'(run * 24'h1357);
               bit tk = exp_cond(4'(cc), fl[3], fl[2], fl[1], fl[0]);
               run++;
               drive_start(op, ext, pc, 4'(fl));
               check(taken == tk, "R1", taken, tk);
               check(new_pc == exp_pc(op, ext, pc, tk), tk ? "R3" : "R4",
                     new_pc, exp_pc(op, ext, pc, tk));
               drain(seq, ntok, seen);
               check(seen, "R8", seen, 1);
               check_seq(tk, op, seq, ntok);
               check(new_pc == exp_pc(op, ext, pc, tk), "R12", new_pc, exp_pc(op, ext, pc, tk));
               @(negedge clk);
               if (d == 0) check(!done, "R9", done, 0);
            end
         end
      end

      // Word form with 0xFF low byte, taken, negative extension (R2)
      drive_start(16'h60FF, 16'hFFF0, 24'h000010, 4'h0);
      check(new_pc == 24'h000000, "R2", new_pc, 0);
      drain(seq, ntok, seen);
      // Back-to-back: new request raised during the done cycle (R10)
      check(done, "R10", done, 1);
      drive_start(16'h6704, 16'h0000, 24'h001000, 4'b0100);
      check(taken && new_pc == 24'h001004, "R10", new_pc, 24'h001004);
      drain(seq, ntok, seen);
      check_seq(1'b1, 16'h6704, seq, ntok);
      @(negedge clk);

      // Request while tokens are pending is ignored (R10)
      drive_start(16'h6100, 16'h0100, 24'h002000, 4'h0);
      tok_ready = 1'b0;
      opcode = 16'h6010; pc_in = 24'h00F000; start = 1'b1;
      @(negedge clk); @(negedge clk);
      start = 1'b0;
      check(!taken && new_pc == 24'h002002, "R10", new_pc, 24'h002002);
      tok_ready = 1'b1;
      drain(seq, ntok, seen);
      check_seq(1'b0, 16'h6100, seq, ntok);
      check(new_pc == 24'h002002, "R10", new_pc, 24'h002002);
      @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule